// File: doc/BRIEF.md
# Protected Self-Timed Program Controller

This block sits behind the serial command decoder of a small serial nonvolatile memory model. The decoder hands it one frame at a time, with a pulse that marks the clock in which the final bit of a frame was sampled, plus the decoded operation, word address and data word. The block keeps the write-enable latch. It decides whether a program or erase cycle may begin, which depends on the instant chip select falls compared with the end of the frame. It then runs a fixed-length busy cycle that drives write strobes into a behavioural storage array.

While a cycle is in flight, or after one has finished, raising chip select shows the ready/busy state on the serial output. Low means busy and high means ready. Once the device is ready, the host can release the output by clocking a 1 on the data input. All timing is expressed in system clocks. The serial clock and chip select arrive already brought into that domain: a level for chip select and a one-clock pulse for each rising serial clock edge.

Top module: `nvm_program_ctrl`

## Requirements
- R1: After reset the write-enable latch is clear. A WRITE (op 1), ERASE (op 2), ERASE-ALL (op 3) or WRITE-ALL (op 4) that is received while the latch is clear starts no cycle: busy stays low and no write strobe is issued. Ops 0, 5, 6 and 7 are not program operations.
- R2: A program operation starts only if chip select falls while the frame is armed. The frame is armed by `frame_done` and disarmed by the first following `sk_rise` seen with chip select still high. A late fall is discarded and leaves busy low and the array untouched.
- R3: ENABLE (op 5) sets the latch and DISABLE (op 6) clears it, each on its own `frame_done`. The latch keeps its value until the opposite command arrives or reset is applied.
- R4: WRITE issues exactly two strobes to its address: first all ones (auto-clear), then the data word.
- R5: ERASE writes all ones to one address. ERASE-ALL writes all ones to every address.
- R6: WRITE-ALL writes the data word to every address. No other location is changed by a single-word operation.
- R7: While busy and with chip select high, `do_oe` is 1 and `do_val` is 0. After the cycle, chip select high gives `do_oe` 1 and `do_val` 1.
- R8: When ready, an `sk_rise` with `di`=1 and chip select high clears the status output (`do_oe` 0 from the next clock). The same stimulus while busy has no effect.
- R9: Busy stays high for exactly CYCLE_CLKS clocks, and strobes occur only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select level, synchronous |
| sk_rise | input | 1 | One-clock pulse per rising serial clock |
| di | input | 1 | Serial data bit sampled with `sk_rise` |
| frame_done | input | 1 | Pulse: last bit of a frame was sampled (coincides with its `sk_rise`) |
| cmd_op | input | 3 | Decoded operation code |
| cmd_addr | input | ADDR_W | Word address of the frame |
| cmd_data | input | DATA_W | Data word of the frame |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Program cycle in progress |
| do_oe | output | 1 | Serial output enable |
| do_val | output | 1 | Serial output value (ready/busy) |

## Verification
The assertions assume that `frame_done` arrives only together with an `sk_rise`. They also assume that chip select is a clean synchronous level, so that a fall is seen in exactly one clock, and that the decoder sends no frames while the block is busy. The bench drives every input on the falling clock edge. It raises `frame_done` only in the same clock as `sk_rise`, and it waits for busy to drop before it sends the next frame. Status-release pulses during the busy cycle are the only serial clocks it sends then.

// File: rtl/nvm_program_ctrl.sv
module nvm_program_ctrl #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int CYCLE_CLKS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk_rise,
  input  logic              di,
  input  logic              frame_done,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              do_oe,
  output logic              do_val
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [2:0] OP_WRITE = 3'd1, OP_ERASE = 3'd2, OP_ERAL = 3'd3,
                         OP_WRAL  = 3'd4, OP_EN    = 3'd5, OP_DIS  = 3'd6;

  logic              wel, armed, stat_en, cs_q;
  logic [2:0]        op_r;
  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] data_r;
  logic [CNT_W-1:0]  cnt;

  wire cs_fall = cs_q & ~cs;
  wire prog_op = (cmd_op >= OP_WRITE) && (cmd_op <= OP_WRAL);
  wire sweep   = (op_r == OP_ERAL) || (op_r == OP_WRAL);
  wire [CNT_W-1:0] n_wr = sweep ? CNT_W'(DEPTH) : (op_r == OP_WRITE ? CNT_W'(2) : CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; armed <= 1'b0; stat_en <= 1'b0; cs_q <= 1'b0; busy <= 1'b0;
      op_r <= '0; addr_r <= '0; data_r <= '0; cnt <= '0;
    end else begin
      cs_q <= cs;
      if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(CYCLE_CLKS - 1)) busy <= 1'b0;
      end else begin
        if (cs && sk_rise && di) stat_en <= 1'b0;
        if (armed && cs_fall) begin
          armed <= 1'b0;
          if (wel) begin
            busy <= 1'b1; cnt <= '0; stat_en <= 1'b1;
          end
        end else if (frame_done) begin
          if (cmd_op == OP_EN)  wel <= 1'b1;
          if (cmd_op == OP_DIS) wel <= 1'b0;
          armed  <= prog_op;
          op_r   <= cmd_op;
          addr_r <= cmd_addr;
          data_r <= cmd_data;
        end else if (armed && sk_rise && cs) begin
          armed <= 1'b0;
        end
      end
    end
  end

  assign mem_we    = busy && (cnt < n_wr);
  assign mem_addr  = sweep ? cnt[ADDR_W-1:0] : addr_r;
  assign mem_wdata = (op_r == OP_WRAL || (op_r == OP_WRITE && cnt == CNT_W'(1))) ? data_r : '1;
  assign do_oe     = cs & stat_en;
  assign do_val    = ~busy;

  // R1: a cycle begins only with the latch set
  a_r1_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // R2: start follows a chip-select fall
  a_r2_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(cs) && $past(cs, 2)));
  // R4: the first strobe of a WRITE clears the word
  a_r4_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we) && op_r == OP_WRITE) |-> (mem_wdata == '1));
  // R8: status cannot be released while busy
  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(stat_en)) |-> stat_en);
  // R9: strobes only while busy, and the cycle ends at the full count
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);
  a_r9_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == CNT_W'(CYCLE_CLKS - 1)));
endmodule

// File: tb/nvm_program_ctrl_test.sv
module nvm_program_ctrl_test;
  localparam int AW = 4, DW = 8, CYC = 40, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, cs = 0, sk_rise = 0, di = 0, frame_done = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [DW-1:0] cmd_data = 0;
  logic mem_we, busy, do_oe, do_val;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  nvm_program_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_CLKS(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise), .di(di),
    .frame_done(frame_done), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .do_oe(do_oe), .do_val(do_val));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, wr_count = 0, last_len = 0;
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] model  [DEPTH];
  logic [DW-1:0] first_wd;

  always @(negedge clk) if (mem_we) begin
    if (wr_count == 0) first_wd = mem_wdata;
    shadow[mem_addr] = mem_wdata;
    wr_count++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cs = 1; tick;
    frame_done = 1; sk_rise = 1; cmd_op = op; cmd_addr = a; cmd_data = d; tick;
    frame_done = 0; sk_rise = 0;
  endtask

  task automatic run(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_count = 0;
    send(op, a, d);
    cs = 0; tick;
    last_len = 0;
    while (busy && last_len < 1000) begin last_len++; tick; end
    tick;
  endtask

  task automatic cmp_array(input string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) if (shadow[i] !== model[i]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic t_reset;
    chk("R1 reset busy", busy, 0);
    chk("R9 reset strobe", mem_we, 0);
    chk("R7 reset do_oe", do_oe, 0);
  endtask

  task automatic t_locked;
    run(3'd1, 4'd3, 8'h5A);
    chk("R1 locked busy", last_len, 0);
    chk("R1 locked strobes", wr_count, 0);
    cmp_array("R1 locked array");
  endtask

  task automatic t_write;
    send(3'd5, 0, 0); cs = 0; tick;
    run(3'd1, 4'd3, 8'h5A);
    model[3] = 8'h5A;
    chk("R3 enable then write runs", last_len, CYC);
    chk("R9 busy length", last_len, CYC);
    chk("R4 strobe count", wr_count, 2);
    chk("R4 auto-clear first", first_wd, 8'hFF);
    cmp_array("R6 write touches one word");
  endtask

  task automatic t_missed;
    wr_count = 0;
    send(3'd1, 4'd7, 8'h11);
    sk_rise = 1; tick; sk_rise = 0;
    cs = 0; tick; tick; tick;
    chk("R2 late fall busy", busy, 0);
    chk("R2 late fall strobes", wr_count, 0);
    cmp_array("R2 late fall array");
  endtask

  task automatic t_erase;
    run(3'd2, 4'd3, 8'h00);
    model[3] = 8'hFF;
    chk("R5 erase strobes", wr_count, 1);
    cmp_array("R5 erase word");
  endtask

  task automatic t_all;
    run(3'd4, 0, 8'hC3);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hC3;
    chk("R6 write-all strobes", wr_count, DEPTH);
    cmp_array("R6 write-all array");
    run(3'd3, 0, 8'h00);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    chk("R5 erase-all strobes", wr_count, DEPTH);
    cmp_array("R5 erase-all array");
  endtask

  task automatic t_status;
    wr_count = 0;
    send(3'd1, 4'd9, 8'h3C); cs = 0; tick;
    model[9] = 8'h3C;
    tick; cs = 1; tick;
    chk("R7 busy do_oe", do_oe, 1);
    chk("R7 busy do_val", do_val, 0);
    di = 1; sk_rise = 1; tick; sk_rise = 0; di = 0; tick;
    chk("R8 release ignored while busy", do_oe, 1);
    for (int n = 0; busy && n < 1000; n++) tick;
    tick;
    chk("R7 ready do_val", do_val, 1);
    chk("R7 ready do_oe", do_oe, 1);
    di = 1; sk_rise = 1; tick; sk_rise = 0; di = 0;
    chk("R8 release when ready", do_oe, 0);
    cs = 0; tick;
    cmp_array("R6 status run array");
  endtask

  task automatic t_disable;
    send(3'd6, 0, 0); cs = 0; tick;
    run(3'd2, 4'd9, 0);
    chk("R3 disabled erase busy", last_len, 0);
    chk("R3 disabled strobes", wr_count, 0);
    cmp_array("R3 disabled array");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin shadow[i] = 8'h00; model[i] = 8'h00; end
    tick; tick;
    t_reset;
    rst_n = 1; tick;
    t_locked;
    t_write;
    t_missed;
    t_erase;
    t_all;
    t_status;
    t_disable;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule